// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a synchronous host and a 1M x 1 asynchronous dynamic RAM. It takes single-bit read and write requests with a 20-bit word address. It turns each one into row-strobe and column-strobe sequences on a 10-bit multiplexed address bus. The upper ten address bits select the row and the lower ten select the column. Every analogue timing limit is a parameter in nanoseconds, and the block rounds each one up to whole clock cycles at the configured clock period. One netlist therefore covers every speed grade.

After a row has been opened, the controller keeps it open. A later request to the same row costs only a column strobe cycle (page hit). A request to another row closes the open row, waits out the precharge time and then opens the new row. The row is also closed on its own before the longest allowed row-strobe pulse runs out, even while hits keep arriving. Writes are always early writes, so the output enable stays inactive and the data pin stays high impedance for the whole cycle. A refresh agent can ask for the bus. The controller finishes the access in flight, closes the row and holds a grant until the agent lets go.

Top module: `fpdram_ctrl`

## Requirements
- R1: After reset, all four strobes (row, column, write, output enable; active low) are high, the grant and read-valid outputs are low, and the request channel is ready.
- R2: When the row strobe falls, the address pins carry request address bits [19:10]. When the column strobe falls, they carry bits [9:0]. The row value is held for at least the row-hold count of cycles after the row strobe falls, and the pins do not change while the column strobe is low.
- R3: The column strobe falls no sooner than the row-to-column delay count of cycles after the row strobe falls.
- R4: A request whose row equals the open row, with the row strobe held low, causes only a column strobe cycle, with no new falling edge of the row strobe.
- R5: A request to a different row raises the row strobe. The strobe stays high for at least the precharge count of cycles before it falls for the new row, and every fall of the row strobe obeys this minimum.
- R6: The column strobe stays low for at least the column pulse count of cycles. Inside one open row it stays high for at least the column precharge count of cycles, and two falling edges are at least the page cycle count of cycles apart. The column strobe is low only while the row strobe is low.
- R7: Read data is sampled as the column strobe rises. This edge comes no sooner than the column access count after the column strobe fell and the row access count after the row strobe fell. The data is returned on a one-cycle read-valid pulse.
- R8: On a write, the write strobe is low and the data pin is driven before the column strobe falls. The output enable stays high for the whole write cycle.
- R9: The row strobe never stays low longer than the maximum page pulse count of cycles. The row is closed in time even under a continuous stream of hits.
- R10: A refresh request finishes the current access and closes the row. The grant is then raised, and it is high only while the row and column strobes are both high. No host request is accepted while the grant is high. After the grant is released, a full precharge precedes the next row strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Request accepted on this edge when valid is high |
| req_addr_i | input | 20 | Word address: [19:10] row, [9:0] column |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 1 | Write data bit |
| rd_valid_o | output | 1 | One-cycle pulse with read data |
| rd_data_o | output | 1 | Read data bit |
| ref_req_i | input | 1 | Refresh agent asks for the bus (level) |
| ref_gnt_o | output | 1 | Bus granted to refresh agent |
| dram_a_o | output | 10 | Multiplexed row/column address |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_we_no | output | 1 | Write strobe, active low |
| dram_oe_no | output | 1 | Output enable, active low |
| dram_d_o | output | 1 | Data to memory |
| dram_q_i | input | 1 | Data from memory |

## Verification
The bench probes the first access after reset, hits at column 0 and column 1023, and misses between row 0 and row 1023. A design that treats a hit as a miss shows an extra falling edge of the row strobe. A design that mixes up the row and column fields reads back consistent data but fails the address check taken at each strobe edge. A long stream of hits to one row must lead to an early close. A design without the pulse-width guard keeps the row strobe low past its limit. A refresh request arrives while a row is open and a host request is pending. A design that grants with the row still open, or that accepts the pending request during the grant, or that skips the precharge afterwards, breaks the strobe rules the bench measures at every edge.

// File: rtl/fpdram_pkg.sv
package fpdram_pkg;
  typedef enum logic [2:0] {
    S_CLOSED, S_ROW, S_CAS, S_CPRE, S_OPEN, S_HIT, S_REF
  } state_e;

  function automatic int ns2cyc(input int ns, input int period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/fpdram_tmr.sv
module fpdram_tmr #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  // high when the interval ends at the coming edge
  assign done_o = (cnt_q <= W'(1));
endmodule

// File: rtl/fpdram_page_guard.sv
module fpdram_page_guard #(
  parameter int RASP_C  = 20000,
  parameter int GUARD_C = 19980
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ras_low_i,
  output logic old_o
);
  localparam int CW = $clog2(RASP_C + 1) + 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!ras_low_i)              cnt_q <= '0;
    else if (cnt_q < CW'(RASP_C))     cnt_q <= cnt_q + 1'b1;
  end

  assign old_o = (cnt_q >= CW'(GUARD_C));

  p_ras_width_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ras_low_i |-> (cnt_q < CW'(RASP_C)))
    else $error("row strobe low beyond page limit");
endmodule

// File: rtl/fpdram_ctrl.sv
module fpdram_ctrl
  import fpdram_pkg::*;
#(
  parameter int ROW_W     = 10,
  parameter int COL_W     = 10,
  parameter int CLK_NS    = 5,
  parameter int T_RP_NS   = 40,
  parameter int T_RAS_NS  = 60,
  parameter int T_RCD_NS  = 20,
  parameter int T_RAH_NS  = 10,
  parameter int T_CAS_NS  = 15,
  parameter int T_CP_NS   = 10,
  parameter int T_PC_NS   = 40,
  parameter int T_RAC_NS  = 60,
  parameter int T_CAC_NS  = 15,
  parameter int T_RASP_NS = 100000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic [ROW_W+COL_W-1:0] req_addr_i,
  input  logic                 req_we_i,
  input  logic                 req_wdata_i,
  output logic                 rd_valid_o,
  output logic                 rd_data_o,
  input  logic                 ref_req_i,
  output logic                 ref_gnt_o,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_a_o,
  output logic                 dram_ras_no,
  output logic                 dram_cas_no,
  output logic                 dram_we_no,
  output logic                 dram_oe_no,
  output logic                 dram_d_o,
  input  logic                 dram_q_i
);
  localparam int MA_W    = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int RP_C    = imax(ns2cyc(T_RP_NS, CLK_NS), 1);
  localparam int RAS_C   = imax(ns2cyc(T_RAS_NS, CLK_NS), 1);
  localparam int RAH_C   = imax(ns2cyc(T_RAH_NS, CLK_NS), 1);
  localparam int RCD_C   = imax(ns2cyc(T_RCD_NS, CLK_NS), RAH_C + 1);
  localparam int CAS_C   = imax(ns2cyc(T_CAS_NS, CLK_NS), 1);
  localparam int CP_C    = imax(ns2cyc(T_CP_NS, CLK_NS), 1);
  localparam int PC_C    = imax(ns2cyc(T_PC_NS, CLK_NS), 1);
  localparam int RAC_C   = imax(ns2cyc(T_RAC_NS, CLK_NS), 1);
  localparam int CAC_C   = imax(ns2cyc(T_CAC_NS, CLK_NS), 1);
  localparam int RASP_C  = ns2cyc(T_RASP_NS, CLK_NS);
  localparam int MARGIN  = imax(CAS_C, CAC_C) + imax(CP_C, PC_C) + 4;
  localparam int GUARD_C = RASP_C - MARGIN;
  localparam int TMAX    = imax(imax(RP_C, RAS_C), imax(PC_C, RAC_C));
  localparam int TW      = $clog2(TMAX + 1) + 1;
  localparam int CW      = $clog2(imax(RCD_C, imax(imax(CAS_C, CAC_C), imax(CP_C, RAC_C))) + 1) + 1;
  localparam int HW      = $clog2(RP_C + 1) + 1;

  state_e              state_q;
  logic [CW-1:0]       cnt_q;
  logic [ROW_W-1:0]    open_row_q;
  logic [COL_W-1:0]    col_q;
  logic                wr_q, wd_q;
  logic                rp_done, rac_done, rasmin_done, pc_done, page_old;

  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  assign req_row = req_addr_i[ROW_W+COL_W-1:COL_W];
  assign req_col = req_addr_i[COL_W-1:0];

  logic row_match, hit_ok, close_req, open_acc, cas_fall, cas_end;
  assign row_match = (req_row == open_row_q);
  assign hit_ok    = req_valid_i && row_match && !ref_req_i && !page_old;
  assign close_req = ref_req_i || page_old || (req_valid_i && !row_match);
  assign open_acc  = (state_q == S_CLOSED) && rp_done && !ref_req_i && req_valid_i;
  assign cas_fall  = ((state_q == S_ROW) && (cnt_q == CW'(RCD_C - 1))) || (state_q == S_HIT);
  assign cas_end   = (cnt_q >= CW'(CAS_C - 1)) &&
                     (wr_q || ((cnt_q >= CW'(CAC_C - 1)) && rac_done));

  logic ras_rise;
  assign ras_rise = ((state_q == S_OPEN) && !hit_ok && close_req && rasmin_done) ||
                    ((state_q == S_REF) && !ref_req_i);

  assign req_ready_o = ((state_q == S_CLOSED) && rp_done && !ref_req_i) ||
                       ((state_q == S_OPEN) && hit_ok);
  assign ref_gnt_o   = (state_q == S_REF);

  fpdram_tmr #(.W(TW)) u_rp (
    .clk_i, .rst_ni, .load_i(ras_rise), .val_i(TW'(RP_C)), .done_o(rp_done));
  fpdram_tmr #(.W(TW)) u_rac (
    .clk_i, .rst_ni, .load_i(open_acc), .val_i(TW'(RAC_C)), .done_o(rac_done));
  fpdram_tmr #(.W(TW)) u_rasmin (
    .clk_i, .rst_ni, .load_i(open_acc), .val_i(TW'(RAS_C)), .done_o(rasmin_done));
  fpdram_tmr #(.W(TW)) u_pc (
    .clk_i, .rst_ni, .load_i(cas_fall), .val_i(TW'(PC_C)), .done_o(pc_done));

  fpdram_page_guard #(.RASP_C(RASP_C), .GUARD_C(GUARD_C)) u_guard (
    .clk_i, .rst_ni, .ras_low_i(!dram_ras_no), .old_o(page_old));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_CLOSED;
      cnt_q       <= '0;
      open_row_q  <= '0;
      col_q       <= '0;
      wr_q        <= 1'b0;
      wd_q        <= 1'b0;
      dram_a_o    <= '0;
      dram_ras_no <= 1'b1;
      dram_cas_no <= 1'b1;
      dram_we_no  <= 1'b1;
      dram_oe_no  <= 1'b1;
      dram_d_o    <= 1'b0;
      rd_valid_o  <= 1'b0;
      rd_data_o   <= 1'b0;
    end else begin
      rd_valid_o <= 1'b0;
      unique case (state_q)
        S_CLOSED: begin
          if (ref_req_i && rp_done) begin
            state_q <= S_REF;
          end else if (open_acc) begin
            dram_ras_no <= 1'b0;
            dram_a_o    <= MA_W'(req_row);
            open_row_q  <= req_row;
            col_q       <= req_col;
            wr_q        <= req_we_i;
            wd_q        <= req_wdata_i;
            cnt_q       <= '0;
            state_q     <= S_ROW;
          end
        end
        S_ROW: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW'(RAH_C - 1)) begin
            dram_a_o   <= MA_W'(col_q);
            dram_we_no <= !wr_q;
            dram_d_o   <= wd_q;
          end
          if (cnt_q == CW'(RCD_C - 1)) begin
            dram_cas_no <= 1'b0;
            dram_oe_no  <= wr_q;
            cnt_q       <= '0;
            state_q     <= S_CAS;
          end
        end
        S_CAS: begin
          cnt_q <= cnt_q + 1'b1;
          if (cas_end) begin
            dram_cas_no <= 1'b1;
            dram_we_no  <= 1'b1;
            dram_oe_no  <= 1'b1;
            if (!wr_q) begin
              rd_data_o  <= dram_q_i;
              rd_valid_o <= 1'b1;
            end
            cnt_q   <= '0;
            state_q <= S_CPRE;
          end
        end
        S_CPRE: begin
          if (cnt_q < CW'(CP_C)) cnt_q <= cnt_q + 1'b1;
          if ((cnt_q >= CW'(CP_C - 1)) && pc_done) state_q <= S_OPEN;
        end
        S_OPEN: begin
          if (hit_ok) begin
            dram_a_o   <= MA_W'(req_col);
            col_q      <= req_col;
            wr_q       <= req_we_i;
            wd_q       <= req_wdata_i;
            dram_we_no <= !req_we_i;
            dram_d_o   <= req_wdata_i;
            state_q    <= S_HIT;
          end else if (ras_rise) begin
            dram_ras_no <= 1'b1;
            state_q     <= S_CLOSED;
          end
        end
        S_HIT: begin
          dram_cas_no <= 1'b0;
          dram_oe_no  <= wr_q;
          cnt_q       <= '0;
          state_q     <= S_CAS;
        end
        S_REF: begin
          if (!ref_req_i) state_q <= S_CLOSED;
        end
        default: state_q <= S_CLOSED;
      endcase
    end
  end

  // consecutive cycles with row strobe high, saturating
  logic [HW-1:0] hi_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     hi_cnt_q <= HW'(RP_C);
    else if (!dram_ras_no)           hi_cnt_q <= '0;
    else if (hi_cnt_q < HW'(RP_C))   hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  p_precharge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_ras_no) |-> (hi_cnt_q >= HW'(RP_C)))
    else $error("row precharge too short");
  p_cas_in_row_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_cas_no |-> !dram_ras_no)
    else $error("column strobe without row");
  p_col_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dram_cas_no && $past(!dram_cas_no)) |-> $stable(dram_a_o))
    else $error("address moved under column strobe");
  p_write_hiz_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_we_no |-> dram_oe_no)
    else $error("output enabled during write");
  p_gnt_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_gnt_o |-> (dram_ras_no && dram_cas_no && !req_ready_o))
    else $error("grant with bus busy");
  p_rvalid_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $rose(dram_cas_no))
    else $error("read data not taken at column strobe rise");
endmodule

// File: tb/fpdram_ctrl_test.sv
module fpdram_ctrl_test;
  localparam int CLK_NS  = 5;
  localparam int RASP_NS = 3000;
  function automatic int cyc(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  localparam int E_RP   = cyc(40);
  localparam int E_RCD  = cyc(20);
  localparam int E_RAH  = cyc(10);
  localparam int E_CAS  = cyc(15);
  localparam int E_CP   = cyc(10);
  localparam int E_PC   = cyc(40);
  localparam int E_RAC  = cyc(60);
  localparam int E_CAC  = cyc(15);
  localparam int E_RASP = cyc(RASP_NS);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, req_wdata = 1'b0, ref_req = 1'b0;
  logic [19:0] req_addr = '0;
  logic req_ready, rd_valid, rd_data, ref_gnt;
  logic [9:0] dram_a;
  logic ras_n, cas_n, we_n, oe_n, dram_d, dram_q;

  always #2.5 clk = ~clk;

  fpdram_ctrl #(.T_RASP_NS(RASP_NS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_we_i(req_we), .req_wdata_i(req_wdata),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .ref_req_i(ref_req), .ref_gnt_o(ref_gnt),
    .dram_a_o(dram_a), .dram_ras_no(ras_n), .dram_cas_no(cas_n), .dram_we_no(we_n),
    .dram_oe_no(oe_n), .dram_d_o(dram_d), .dram_q_i(dram_q));

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory model and strobe monitor, sampled on falling clock edges
  logic mem [int];
  logic exp_mem [int];
  logic [9:0] m_row = '0, m_col = '0;
  logic model_bit = 1'b0;
  assign dram_q = (!cas_n && !oe_n) ? model_bit : 1'b0;

  logic [9:0] op_row = '0, op_col = '0;
  logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1, p_oe = 1'b1;
  int ras_falls = 0, ras_hi = 1000, ras_lo = 0, max_ras_lo = 0;
  int since_ras = 0, since_cas = 0, cas_lo = 0, cas_hi = 0;
  bit page_act = 0, mon_on = 0;
  int v_mux = 0, v_rcd = 0, v_rp = 0, v_cas = 0, v_cp = 0, v_pc = 0, v_rd = 0;
  int v_we = 0, v_oe = 0, v_gnt = 0, v_rah = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      since_ras++; since_cas++;
      if (p_ras && !ras_n) begin
        ras_falls++;
        if (ras_hi < E_RP) v_rp++;
        if (dram_a != op_row) v_mux++;
        m_row = dram_a; since_ras = 0; ras_lo = 0;
      end
      if (!p_ras && ras_n) begin page_act = 0; ras_hi = 0; end
      if (!ras_n) begin ras_lo++; if (ras_lo > max_ras_lo) max_ras_lo = ras_lo; end
      else ras_hi++;
      if (!ras_n && since_ras > 0 && since_ras < E_RAH && dram_a != m_row) v_rah++;
      if (p_cas && !cas_n) begin
        if (since_ras < E_RCD) v_rcd++;
        if (dram_a != op_col) v_mux++;
        if (page_act && cas_hi < E_CP) v_cp++;
        if (page_act && since_cas < E_PC) v_pc++;
        if (!we_n && p_we) v_we++;
        m_col = dram_a; since_cas = 0; cas_lo = 0; page_act = 1;
        if (!we_n) mem[{m_row, m_col}] = dram_d;
        model_bit = mem.exists({m_row, m_col}) ? mem[{m_row, m_col}] : 1'b0;
      end
      if (!p_cas && cas_n) begin
        if (cas_lo < E_CAS) v_cas++;
        if (!p_oe && (cas_lo < E_CAC || since_ras < E_RAC)) v_rd++;
        cas_hi = 0;
      end
      if (!cas_n) cas_lo++; else cas_hi++;
      if (!we_n && !oe_n) v_oe++;
      if (ref_gnt && (!ras_n || !cas_n)) v_gnt++;
    end
    p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_oe = oe_n;
  end

  int cyc_cnt = 0;
  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask
  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000) begin
      chk(0, "watchdog", cyc_cnt, 100000);
      finish_run();
    end
  end

  bit open_v = 0;
  logic [9:0] open_row = '0;
  int data_err = 0;

  task automatic do_op(input logic wr, input logic [19:0] a, input logic d,
                       input bit chk_fall, input bit quiet);
    int f0, n, exp_f;
    logic e;
    f0 = ras_falls;
    exp_f = (open_v && open_row == a[19:10]) ? 0 : 1;
    @(negedge clk);
    op_row = a[19:10]; op_col = a[9:0];
    req_valid = 1'b1; req_addr = a; req_we = wr; req_wdata = d;
    n = 0;
    while (!req_ready && n < 400) begin @(negedge clk); n++; end
    if (n >= 400) chk(0, "R4 accept timeout", n, 0);
    @(posedge clk); #1; req_valid = 1'b0;
    if (!wr) begin
      n = 0;
      do begin @(negedge clk); n++; end while (!rd_valid && n < 100);
      e = exp_mem.exists(a) ? exp_mem[a] : 1'b0;
      if (quiet) begin if (rd_data !== e || !rd_valid) data_err++; end
      else chk(rd_valid && rd_data === e, "R7 read data", int'(rd_data), int'(e));
    end else begin
      repeat (12) @(negedge clk);
      exp_mem[a] = d;
    end
    if (chk_fall)
      chk(ras_falls - f0 == exp_f, exp_f ? "R5 miss reopens row" : "R4 hit keeps row",
          ras_falls - f0, exp_f);
    open_v = 1; open_row = a[19:10];
  endtask

  // {write, address, data}
  localparam logic [21:0] VEC [16] = '{
    {1'b1, 20'h00005, 1'b1}, {1'b1, 20'h00006, 1'b0}, {1'b1, 20'h003FF, 1'b1},
    {1'b0, 20'h00005, 1'b0}, {1'b0, 20'h00006, 1'b0}, {1'b0, 20'h003FF, 1'b0},
    {1'b1, 20'hFFC00, 1'b1}, {1'b1, 20'hFFFFF, 1'b1}, {1'b0, 20'h00005, 1'b0},
    {1'b0, 20'hFFFFF, 1'b0}, {1'b0, 20'hFFC00, 1'b0}, {1'b1, 20'h12345, 1'b1},
    {1'b1, 20'h12344, 1'b0}, {1'b0, 20'h12345, 1'b0}, {1'b0, 20'h12344, 1'b0},
    {1'b0, 20'h00000, 1'b0}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, sampled while reset is held and after release
    chk(ras_n && cas_n && we_n && oe_n, "R1 strobes high in reset",
        int'({ras_n, cas_n, we_n, oe_n}), 15);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1;
    chk(!ref_gnt && !rd_valid, "R1 grant and read-valid low", int'({ref_gnt, rd_valid}), 0);
    chk(req_ready, "R1 ready after reset", int'(req_ready), 1);

    for (int i = 0; i < 16; i++)
      do_op(VEC[i][21], VEC[i][20:1], VEC[i][0], 1, 0);

    // R10 refresh while a row is open and a request is waiting
    @(negedge clk);
    ref_req = 1'b1;
    begin
      int n = 0;
      while (!ref_gnt && n < 60) begin @(negedge clk); n++; end
      chk(ref_gnt && ras_n && cas_n, "R10 grant with row closed",
          int'({ref_gnt, ras_n, cas_n}), 7);
      req_valid = 1'b1; req_addr = 20'h00000; req_we = 1'b0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (req_ready || rd_valid || !ras_n) n = -1;
      end
      chk(n >= 0, "R10 no access during grant", n, 0);
      req_valid = 1'b0;
      ref_req = 1'b0;
      open_v = 0;
    end
    do_op(1'b0, 20'h12345, 1'b0, 1, 0);

    // R9 long stream of hits to one row
    begin
      int f0 = ras_falls;
      for (int k = 0; k < 90; k++)
        do_op(1'b0, (k % 2) ? 20'h12344 : 20'h12345, 1'b0, 0, 1);
      chk(ras_falls - f0 >= 1, "R9 row closed under hit stream", ras_falls - f0, 1);
      chk(max_ras_lo <= E_RASP, "R9 row strobe width", max_ras_lo, E_RASP);
      chk(data_err == 0, "R7 hit stream data", data_err, 0);
    end

    repeat (20) @(negedge clk);
    chk(v_mux == 0, "R2 row/column on address pins", v_mux, 0);
    chk(v_rah == 0, "R2 row hold", v_rah, 0);
    chk(v_rcd == 0, "R3 row to column delay", v_rcd, 0);
    chk(v_rp == 0, "R5 precharge width", v_rp, 0);
    chk(v_cas == 0, "R6 column pulse width", v_cas, 0);
    chk(v_cp == 0, "R6 column precharge", v_cp, 0);
    chk(v_pc == 0, "R6 page cycle", v_pc, 0);
    chk(v_rd == 0, "R7 access times", v_rd, 0);
    chk(v_we == 0, "R8 write strobe before column", v_we, 0);
    chk(v_oe == 0, "R8 output disabled on write", v_oe, 0);
    chk(v_gnt == 0, "R10 strobes idle under grant", v_gnt, 0);
    finish_run();
  end
endmodule